// File: doc/BRIEF.md
# Keccak Lane Vector Unit

This execution unit carries out the four bitwise helper operations used by SHA-3 style permutations on a 128-bit vector. The vector is split into two independent 64-bit lanes. The unit receives a 32-bit instruction word together with three source vector values (n, m and a). It classifies the word against fixed mask/match patterns and pulls out the operation selector and the rotate immediate. One clock later it presents either the 128-bit result with a valid strobe, or an undefined-instruction flag.

Register-file reads and writes are handled outside the unit, and so is the sequencing of the permutation. The destination and source register number fields inside the word therefore play no part in the computation. Any word the unit does not own, including encodings that belong to a neighbouring extension, is reported as undefined. The issue stage can then route it elsewhere or raise an exception.

Top module: `keccak_vec_unit`

## Requirements
- R1: A word with (word & 0xff808000) == 0xce000000 and selector bits [22:21] == 0 produces, in each lane, n ^ m ^ a.
- R2: A word in that same four-operand group with selector bits [22:21] == 1 produces, in each lane, n ^ (m & ~a).
- R3: A four-operand group word with selector bits [22:21] equal to 2 or 3 is not handled: it raises the undefined flag and no valid strobe.
- R4: A word with (word & 0xffe00000) == 0xce800000 produces, in each lane, (n ^ m) rotated right by the 6-bit immediate in bits [15:10]. An immediate of 0 gives the plain XOR.
- R5: A word with (word & 0xffe0b000) == 0xce608000, bit 14 == 0 and bits [11:10] == 3 produces, in each lane, n ^ (m rotated left by 1). Any other word in that group (bit 14 == 1, or bits [11:10] from 0 to 2) is undefined.
- R6: Lane 0 occupies vector bits [63:0] and lane 1 occupies bits [127:64]. Each lane's result depends only on the same lane of the sources, and no rotate carries bits across the lane boundary.
- R7: An issued word that matches none of the three groups raises the undefined flag.
- R8: The valid strobe and the undefined flag come from registers. They are asserted in the cycle after the word is issued and are never high together. Both are low in the cycle after a cycle with no issue.
- R9: The result output changes only when a handled operation completes. It holds its value across undefined and idle cycles.
- R10: During and right after reset, the valid strobe and the undefined flag are low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| issueValid | input | 1 | An instruction word is presented this cycle |
| insnWord | input | 32 | Instruction word to classify |
| srcN | input | 128 | First source vector (two 64-bit lanes) |
| srcM | input | 128 | Second source vector |
| srcA | input | 128 | Third source vector (four-operand group only) |
| resValid | output | 1 | Result is valid (one cycle after issue) |
| resData | output | 128 | Result vector |
| undefFlag | output | 1 | Issued word is not handled by this unit |

## Verification
On every cycle the assertions check the following: the valid strobe and the undefined flag never overlap, both drop after a cycle with no issue, and the result holds while an undefined word or an idle cycle is seen. They also check that a three-way XOR word or an undefined selector lands on the expected output one cycle later. Only the bench's scenarios can show the arithmetic of each operation across varied data. This covers rotation at immediates 0, 1, 32 and 63, the single-bit left rotate at lane edges, and lanes carrying unrelated data. The scenarios also classify every non-owned member of the neighbouring groups and a long mixed stream of back-to-back operations, compared against a behavioural model.

// File: rtl/kvu_pkg.sv
package kvu_pkg;
  localparam int INSN_W = 32;
  localparam int IMM_W  = 6;

  localparam logic [INSN_W-1:0] QUAD_MASK  = 32'hff808000;
  localparam logic [INSN_W-1:0] QUAD_MATCH = 32'hce000000;
  localparam logic [INSN_W-1:0] XROT_MASK  = 32'hffe00000;
  localparam logic [INSN_W-1:0] XROT_MATCH = 32'hce800000;
  localparam logic [INSN_W-1:0] TRIO_MASK  = 32'hffe0b000;
  localparam logic [INSN_W-1:0] TRIO_MATCH = 32'hce608000;

  typedef enum logic [1:0] {
    OP_XOR3   = 2'd0,
    OP_CLRXOR = 2'd1,
    OP_ROLXOR = 2'd2,
    OP_XORROR = 2'd3
  } laneOp_e;

  typedef struct packed {
    logic             load;
    laneOp_e          op;
    logic [IMM_W-1:0] rot;
  } laneCtrl_t;
endpackage

// File: rtl/kvu_ctrl.sv
module kvu_ctrl
  import kvu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [INSN_W-1:0] insnWord,
  output laneCtrl_t         ctrl,
  output logic              resValid,
  output logic              undefFlag
);
  logic       isQuad;
  logic       isXrot;
  logic       isTrio;
  logic [1:0] quadSel;
  logic       quadOk;
  logic       trioOk;

  always_comb begin
    isQuad  = (insnWord & QUAD_MASK) == QUAD_MATCH;
    isXrot  = (insnWord & XROT_MASK) == XROT_MATCH;
    isTrio  = (insnWord & TRIO_MASK) == TRIO_MATCH;
    quadSel = insnWord[22:21];
    // selector 2 belongs to another extension, 3 is unallocated
    quadOk  = isQuad && !quadSel[1];
    trioOk  = isTrio && !insnWord[14] && (insnWord[11:10] == 2'b11);
  end

  always_comb begin
    ctrl.load = issueValid && (quadOk || isXrot || trioOk);
    ctrl.rot  = insnWord[15:10];
    if (isXrot)                   ctrl.op = OP_XORROR;
    else if (trioOk)              ctrl.op = OP_ROLXOR;
    else if (quadSel == 2'd1)     ctrl.op = OP_CLRXOR;
    else                          ctrl.op = OP_XOR3;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      undefFlag <= 1'b0;
    end else begin
      resValid  <= ctrl.load;
      undefFlag <= issueValid && !ctrl.load;
    end
  end
endmodule

// File: rtl/kvu_lane.sv
module kvu_lane
  import kvu_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  laneOp_e           op,
  input  logic [IMM_W-1:0]  rot,
  input  logic [LANE_W-1:0] laneN,
  input  logic [LANE_W-1:0] laneM,
  input  logic [LANE_W-1:0] laneA,
  output logic [LANE_W-1:0] laneRes
);
  localparam int SH_W = $clog2(LANE_W) + 1;

  function automatic logic [LANE_W-1:0] rotRight(logic [LANE_W-1:0] x,
                                                 logic [SH_W-1:0] amt);
    logic [SH_W-1:0] back;
    back = SH_W'(LANE_W) - amt;
    return (x >> amt) | (x << back);
  endfunction

  logic [LANE_W-1:0] mixNM;
  logic [SH_W-1:0]   rotAmt;

  always_comb begin
    mixNM  = laneN ^ laneM;
    rotAmt = SH_W'(rot) % SH_W'(LANE_W);
    case (op)
      OP_XOR3:   laneRes = mixNM ^ laneA;
      OP_CLRXOR: laneRes = laneN ^ (laneM & ~laneA);
      OP_ROLXOR: laneRes = laneN ^ {laneM[LANE_W-2:0], laneM[LANE_W-1]};
      OP_XORROR: laneRes = rotRight(mixNM, rotAmt);
      default:   laneRes = '0;
    endcase
  end
endmodule

// File: rtl/kvu_dp.sv
module kvu_dp
  import kvu_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  laneCtrl_t               ctrl,
  input  logic [LANES*LANE_W-1:0] srcN,
  input  logic [LANES*LANE_W-1:0] srcM,
  input  logic [LANES*LANE_W-1:0] srcA,
  output logic [LANES*LANE_W-1:0] resData
);
  localparam int VEC_W = LANES * LANE_W;

  logic [VEC_W-1:0] laneOut;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    kvu_lane #(.LANE_W(LANE_W)) uLane (
      .op     (ctrl.op),
      .rot    (ctrl.rot),
      .laneN  (srcN[g*LANE_W +: LANE_W]),
      .laneM  (srcM[g*LANE_W +: LANE_W]),
      .laneA  (srcA[g*LANE_W +: LANE_W]),
      .laneRes(laneOut[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN)          resData <= '0;
    else if (ctrl.load) resData <= laneOut;
  end
endmodule

// File: rtl/keccak_vec_unit.sv
module keccak_vec_unit
  import kvu_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 64,
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [INSN_W-1:0] insnWord,
  input  logic [VEC_W-1:0]  srcN,
  input  logic [VEC_W-1:0]  srcM,
  input  logic [VEC_W-1:0]  srcA,
  output logic              resValid,
  output logic [VEC_W-1:0]  resData,
  output logic              undefFlag
);
  laneCtrl_t ctrl;

  kvu_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .issueValid(issueValid),
    .insnWord  (insnWord),
    .ctrl      (ctrl),
    .resValid  (resValid),
    .undefFlag (undefFlag)
  );

  kvu_dp #(.LANES(LANES), .LANE_W(LANE_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .srcN   (srcN),
    .srcM   (srcM),
    .srcA   (srcA),
    .resData(resData)
  );
endmodule

// File: rtl/keccak_vec_unit_chk.sv
module keccak_vec_unit_chk
  import kvu_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic [INSN_W-1:0] insnWord,
  input logic [VEC_W-1:0]  srcN,
  input logic [VEC_W-1:0]  srcM,
  input logic [VEC_W-1:0]  srcA,
  input logic              resValid,
  input logic [VEC_W-1:0]  resData,
  input logic              undefFlag
);
  logic inQuad;
  assign inQuad = (insnWord & QUAD_MASK) == QUAD_MATCH;

  // R8: never both
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && undefFlag));

  // R8: idle cycle gives quiet outputs next cycle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> (!resValid && !undefFlag));

  // R1: three-way XOR lands one cycle later
  a_r1_xor3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && inQuad && insnWord[22:21] == 2'd0) |=>
      (resValid && resData == $past(srcN ^ srcM ^ srcA)));

  // R3: selector 2 or 3 is undefined
  a_r3_sel_undef: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && inQuad && insnWord[22]) |=> (undefFlag && !resValid));

  // R9: result holds while no result is produced
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!resValid && $past(rstN)) |-> $stable(resData));
endmodule

bind keccak_vec_unit keccak_vec_unit_chk #(.VEC_W(VEC_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .issueValid(issueValid),
  .insnWord  (insnWord),
  .srcN      (srcN),
  .srcM      (srcM),
  .srcA      (srcA),
  .resValid  (resValid),
  .resData   (resData),
  .undefFlag (undefFlag)
);

// File: tb/sim_keccak_vec_unit.sv
`timescale 1ns/1ps
module sim_keccak_vec_unit;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         issueValid = 1'b0;
  logic [31:0]  insnWord = '0;
  logic [127:0] srcN = '0, srcM = '0, srcA = '0;
  logic         resValid;
  logic [127:0] resData;
  logic         undefFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string curTag = "R10";
  string expTag = "R10";
  logic         expValid = 0, expUndef = 0;
  logic [127:0] expData = '0;

  always #5 clk = ~clk;

  keccak_vec_unit u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .insnWord(insnWord),
    .srcN(srcN), .srcM(srcM), .srcA(srcA),
    .resValid(resValid), .resData(resData), .undefFlag(undefFlag)
  );

  function automatic logic [63:0] refRor(logic [63:0] x, int r);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[i] = x[(i + r) % 64];
    return y;
  endfunction

  function automatic logic [63:0] refRol1(logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[i] = x[(i + 63) % 64];
    return y;
  endfunction

  // behavioural model: decide handled or not, and the lane results
  function automatic bit refEval(logic [31:0] w, logic [127:0] n, logic [127:0] m,
                                 logic [127:0] a, output logic [127:0] r);
    bit ok = 0;
    r = '0;
    for (int l = 0; l < 2; l++) begin
      logic [63:0] ln, lm, la, lr;
      ln = n[l*64 +: 64]; lm = m[l*64 +: 64]; la = a[l*64 +: 64]; lr = '0;
      if (w ==? 32'b1100_1110_0???_????_0???_????_????_????) begin
        if (w[22:21] == 0) begin ok = 1; lr = ln ^ lm ^ la; end
        else if (w[22:21] == 1) begin ok = 1; lr = ln ^ (lm & ~la); end
      end else if (w ==? 32'b1100_1110_100?_????_????_????_????_????) begin
        ok = 1; lr = refRor(ln ^ lm, int'(w[15:10]));
      end else if (w ==? 32'b1100_1110_011?_????_1?00_????_????_????) begin
        if (!w[14] && w[11:10] == 3) begin ok = 1; lr = ln ^ refRol1(lm); end
      end
      r[l*64 +: 64] = lr;
    end
    return ok;
  endfunction

  always @(posedge clk) begin
    logic [127:0] r;
    bit ok;
    expTag = curTag;
    if (!rstN) begin
      expValid = 0; expUndef = 0; expData = '0;
    end else if (issueValid) begin
      ok = refEval(insnWord, srcN, srcM, srcA, r);
      expValid = ok; expUndef = !ok;
      if (ok) expData = r;
    end else begin
      expValid = 0; expUndef = 0;
    end
  end

  always @(posedge clk) begin
    #3;
    if (!finished) begin
      checks++;
      if (resValid !== expValid) begin
        failures++;
        $display("FAIL %s resValid actual=%0b expected=%0b", expTag, resValid, expValid);
      end
      checks++;
      if (undefFlag !== expUndef) begin
        failures++;
        $display("FAIL %s undefFlag actual=%0b expected=%0b", expTag, undefFlag, expUndef);
      end
      checks++;
      if (resData !== expData) begin
        failures++;
        $display("FAIL %s resData actual=%h expected=%h", expTag, resData, expData);
      end
    end
  end

  task automatic send(input logic [31:0] w, input logic [127:0] n,
                      input logic [127:0] m, input logic [127:0] a, input string tag);
    @(negedge clk);
    issueValid = 1; insnWord = w; srcN = n; srcM = m; srcA = a; curTag = tag;
  endtask

  task automatic idle(input int cyc, input string tag);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      issueValid = 0; insnWord = $urandom; srcN = {$urandom, $urandom, $urandom, $urandom};
      curTag = tag;
    end
  endtask

  function automatic logic [31:0] quadW(int sel);
    return 32'hce000000 | (32'(sel) << 21) | ($urandom & 32'h001f7fff);
  endfunction
  function automatic logic [31:0] xrotW(int imm);
    return 32'hce800000 | (32'(imm) << 10) | ($urandom & 32'h001f03ff);
  endfunction
  function automatic logic [31:0] trioW(int b14, int opc);
    return 32'hce608000 | (32'(b14) << 14) | (32'(opc) << 10) | ($urandom & 32'h001f03ff);
  endfunction
  function automatic logic [127:0] rv();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    curTag = "R10";
    repeat (4) @(negedge clk);
    rstN = 1;
    idle(2, "R10");
    // R1 three-way XOR, several patterns
    send(quadW(0), {64'hffff0000ffff0000, 64'h0123456789abcdef},
         {64'h0f0f0f0f0f0f0f0f, 64'hfedcba9876543210}, {64'haaaaaaaaaaaaaaaa, 64'h1}, "R1");
    send(quadW(0), rv(), rv(), rv(), "R1");
    send(quadW(0), '1, '1, '1, "R1");
    // R2 bit clear and XOR
    send(quadW(1), '0, '1, {64'h00000000ffffffff, 64'hf0f0f0f0f0f0f0f0}, "R2");
    send(quadW(1), rv(), rv(), rv(), "R2");
    // R3 selectors 2 and 3 undefined, R9 result holds
    send(quadW(2), rv(), rv(), rv(), "R3");
    send(quadW(3), rv(), rv(), rv(), "R3_R9");
    // R4 XOR and rotate right
    send(xrotW(0), rv(), rv(), rv(), "R4");
    send(xrotW(1), {64'h1, 64'h1}, '0, '0, "R4");
    send(xrotW(63), {64'h8000000000000000, 64'h1}, '0, '0, "R4");
    send(xrotW(32), rv(), rv(), rv(), "R4");
    // R5 rotate-left-one XOR and its group neighbours
    send(trioW(0, 3), '0, {64'h8000000000000000, 64'h8000000000000001}, '0, "R5");
    send(trioW(0, 3), rv(), rv(), rv(), "R5");
    for (int o = 0; o < 3; o++) send(trioW(0, o), rv(), rv(), rv(), "R5");
    send(trioW(1, 3), rv(), rv(), rv(), "R5");
    // R6 lanes independent: lane 1 zero, lane 0 full
    send(xrotW(5), {64'h0, 64'hffffffffffffffff}, '0, '0, "R6");
    send(trioW(0, 3), {64'h0, 64'h0}, {64'h0, 64'h8000000000000000}, '0, "R6");
    // R7 words outside every group
    send(32'h00000000, rv(), rv(), rv(), "R7");
    send(32'hce408000, rv(), rv(), rv(), "R7");
    send(32'hce008000, rv(), rv(), rv(), "R7");
    // R8 idle after activity, R9 hold across idle
    idle(3, "R8_R9");
    // mixed back-to-back stream
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 5))
        0: send(quadW($urandom_range(0, 3)), rv(), rv(), rv(), "R1_R2_R3");
        1: send(xrotW($urandom_range(0, 63)), rv(), rv(), rv(), "R4");
        2: send(trioW($urandom_range(0, 1), $urandom_range(0, 3)), rv(), rv(), rv(), "R5");
        3: send($urandom, rv(), rv(), rv(), "R7");
        4: idle(1, "R8");
        default: send(quadW(0), rv(), rv(), rv(), "R6");
      endcase
    end
    idle(3, "R8");
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule